// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block is a byte-wide register file that stands in for a classic parallel printer port together with the printer attached to it. A host reaches three registers: data, status and control. It selects them with the low three bits of a register address. The printer side is emulated inside the block, so nothing here produces cable timing.

When the strobe bit in the control register goes from 0 to 1, with the init and select bits both high, the last byte the host wrote leaves the block on an 8-bit output stream. That byte is marked by a one-cycle valid pulse. Each status read steps the acknowledge and busy bits through a short fixed cycle, which mimics a printer that answers to polling. A level interrupt output is raised by a control write while interrupts were already enabled, and it is cleared by a status read. An input byte can be captured into a separate latch, and the host reads it through the data register when the direction bit is set.

Reads return data combinationally in the cycle that `bus_rd` is high. The side effects of a read or a write take place at the next rising clock edge. If `bus_wr` and `bus_rd` are high together, the write is performed and the side effects of the read are suppressed.

Top module: `pport_regs`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0xCC, data reads 0xFF and `irq` is low.
- R2: Only address bits 2:0 are decoded: 0 selects data, 1 selects status and 2 selects control. Higher address bits do not change the selection.
- R3: A control write stores the written byte with bits 7:6 forced to 1, and a control read returns the stored value.
- R4: A control write with init (bit 2) equal to 0 loads status with 0xD8 (busy bit 7, acknowledge bit 6, online bit 4 and error bit 3 set; all other bits clear).
- R5: A control write with init = 1, select (bit 3) = 1 and strobe (bit 0) = 1 clears status bit 7. If the stored strobe was 0 before the write, the last written data byte appears on `out_byte`, and `out_valid` is high for exactly one cycle.
- R6: A control write emits no byte when the stored strobe was already 1, or when init or select is 0.
- R7: A control write with init = 1, select = 1 and strobe = 0 sets the pending interrupt, provided the control value stored before the write had interrupt enable (bit 4) set. `irq` always equals the pending flag.
- R8: A status read returns the status value held before the read and clears the pending interrupt.
- R9: After a status read, if busy was clear and the stored strobe is 0, then a set acknowledge is cleared; otherwise acknowledge and busy are both set. If busy was set, or strobe is 1, status is unchanged.
- R10: A data read returns the input latch (loaded from `in_data` when `in_load` is high) if the direction bit (bit 5) is set, and the last written data byte otherwise.
- R11: Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address; only bits 2:0 are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| in_data | input | 8 | Byte captured into the input latch |
| in_load | input | 1 | Captures in_data into the input latch |
| out_byte | output | 8 | Byte sent to the emulated printer |
| out_valid | output | 1 | One-cycle pulse marking out_byte |
| irq | output | 1 | Level interrupt request |

## Verification
The strobe path is driven with a rising strobe, with a strobe held high, and with a strobe raised while select or init is low. This separates true edge detection from a plain level test and shows that both qualifiers are required. The scoreboard queue catches any byte that is missing or extra. Status polling is run once with strobe low, which must walk 0x59, 0x19 and then 0xD9, and once with strobe high, which must freeze the value. Interrupt stimulus writes strobe-low control values with and without a previous enable, to prove that the old control value is the one consulted. Address aliasing, the unused offsets and the direction switch confirm the decoding and the data read-back source.

// File: rtl/pport_pkg.sv
package pport_pkg;
   localparam int BYTE_W = 8;
   localparam int OFS_W  = 3;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic [1:0] {SEL_DATA, SEL_STAT, SEL_CTRL, SEL_NONE} sel_e;

   localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
   localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
   localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

   // status bit positions
   localparam int ST_BUSY = 7;
   localparam int ST_ACK  = 6;
   // control bit positions
   localparam int CT_DIR  = 5;
   localparam int CT_IEN  = 4;
   localparam int CT_SEL  = 3;
   localparam int CT_INIT = 2;
   localparam int CT_STB  = 0;

   localparam byte_t RST_STATUS  = 8'hD9;
   localparam byte_t RST_CTRL    = 8'hCC;
   localparam byte_t RST_DATA    = 8'hFF;
   localparam byte_t INIT_STATUS = 8'hD8;
   localparam byte_t CTRL_FORCE  = 8'hC0;
   localparam byte_t IDLE_READ   = 8'hFF;
endpackage

// File: rtl/pport_decode.sv
module pport_decode
   import pport_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output sel_e              sel,
   output logic              wr_data,
   output logic              wr_ctrl,
   output logic              rd_stat
);
   logic [OFS_W-1:0] ofs;

   generate
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("pport_decode: ADDR_W must cover the register offsets");
      end
   endgenerate

   assign ofs = addr[OFS_W-1:0];

   always_comb begin
      case (ofs)
         OFS_DATA: sel = SEL_DATA;
         OFS_STAT: sel = SEL_STAT;
         OFS_CTRL: sel = SEL_CTRL;
         default:  sel = SEL_NONE;
      endcase
   end

   assign wr_data = wr && (sel == SEL_DATA);
   assign wr_ctrl = wr && (sel == SEL_CTRL);
   assign rd_stat = rd && !wr && (sel == SEL_STAT);
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
   import pport_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_data,
   input  logic  wr_ctrl,
   input  byte_t wdata,
   input  logic  in_load,
   input  byte_t in_data,
   output byte_t ctrl_q,
   output byte_t dataw_q,
   output byte_t datar_q,
   output byte_t out_byte,
   output logic  out_valid
);
   byte_t ctrl_nx;
   logic  fire;

   assign ctrl_nx = wdata | CTRL_FORCE;
   assign fire    = wr_ctrl && ctrl_nx[CT_INIT] && ctrl_nx[CT_SEL]
                    && ctrl_nx[CT_STB] && !ctrl_q[CT_STB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= RST_CTRL;
         dataw_q   <= RST_DATA;
         datar_q   <= RST_DATA;
         out_byte  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= fire;
         if (fire)     out_byte <= dataw_q;
         if (wr_ctrl)  ctrl_q   <= ctrl_nx;
         if (wr_data)  dataw_q  <= wdata;
         if (in_load)  datar_q  <= in_data;
      end
   end

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   a_r6_emit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(wr_ctrl && !ctrl_q[CT_STB]));
   a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_q[7:6] == 2'b11) && (ctrl_q[5:0] == $past(wdata[5:0])));
endmodule

// File: rtl/pport_status.sv
module pport_status
   import pport_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_ctrl,
   input  byte_t wdata,
   input  byte_t ctrl_q,
   input  logic  rd_stat,
   output byte_t status_q,
   output logic  irq
);
   logic pend_q;
   logic poll_step;

   assign poll_step = rd_stat && !status_q[ST_BUSY] && !ctrl_q[CT_STB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= RST_STATUS;
         pend_q   <= 1'b0;
      end else if (wr_ctrl) begin
         if (!wdata[CT_INIT]) begin
            status_q <= INIT_STATUS;
         end else if (wdata[CT_SEL]) begin
            if (wdata[CT_STB])
               status_q[ST_BUSY] <= 1'b0;
            else if (ctrl_q[CT_IEN])
               pend_q <= 1'b1;
         end
      end else if (rd_stat) begin
         pend_q <= 1'b0;
         if (poll_step) begin
            if (status_q[ST_ACK]) begin
               status_q[ST_ACK] <= 1'b0;
            end else begin
               status_q[ST_ACK]  <= 1'b1;
               status_q[ST_BUSY] <= 1'b1;
            end
         end
      end
   end

   assign irq = pend_q;

   a_r4_init_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[CT_INIT]) |=> (status_q == INIT_STATUS));
   a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wr_ctrl && ctrl_q[CT_IEN]));
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> !irq);
   a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && status_q[ST_BUSY]) |=> (status_q == $past(status_q)));
endmodule

// File: rtl/pport_regs.sv
module pport_regs
   import pport_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        in_data,
   input  logic              in_load,
   output logic [7:0]        out_byte,
   output logic              out_valid,
   output logic              irq
);
   sel_e  sel;
   logic  wr_data, wr_ctrl, rd_stat;
   byte_t ctrl_q, dataw_q, datar_q, status_q;

   pport_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .sel     (sel),
      .wr_data (wr_data),
      .wr_ctrl (wr_ctrl),
      .rd_stat (rd_stat)
   );

   pport_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data   (wr_data),
      .wr_ctrl   (wr_ctrl),
      .wdata     (bus_wdata),
      .in_load   (in_load),
      .in_data   (in_data),
      .ctrl_q    (ctrl_q),
      .dataw_q   (dataw_q),
      .datar_q   (datar_q),
      .out_byte  (out_byte),
      .out_valid (out_valid)
   );

   pport_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wdata    (bus_wdata),
      .ctrl_q   (ctrl_q),
      .rd_stat  (rd_stat),
      .status_q (status_q),
      .irq      (irq)
   );

   always_comb begin
      case (sel)
         SEL_DATA: bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
         SEL_STAT: bus_rdata = status_q;
         SEL_CTRL: bus_rdata = ctrl_q;
         default:  bus_rdata = IDLE_READ;
      endcase
   end

   a_r2_ctrl_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr[2:0] == 3'd2)) |-> (bus_rdata[7:6] == 2'b11));
endmodule

// File: tb/pport_regs_bench.sv
module pport_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] in_data = '0;
   logic       in_load = 1'b0;
   logic [7:0] out_byte;
   logic       out_valid;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   pport_regs #(.ADDR_W(4)) u_pport_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .in_data(in_data), .in_load(in_load), .out_byte(out_byte),
      .out_valid(out_valid), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit emits,
                     input logic [7:0] exp_b);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (emits) exp_q.push_back(exp_b);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      check(bus_rdata === exp, tag, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // monitor: every emitted byte must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected byte", out_byte, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(out_byte === e, "R5 emitted byte", out_byte, e);
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      check(irq === 1'b0, "R1 irq", irq, 0);
      rd(4'd2, 8'hCC, "R1 control");
      rd(4'd1, 8'hD9, "R1 status");
      rd(4'd0, 8'hFF, "R1 data");
      // R10 data write read-back, direction out
      wr(4'd0, 8'h5A, 0, 0);
      rd(4'd0, 8'h5A, "R10 written byte");
      // R5 strobe rise emits and clears busy
      wr(4'd2, 8'h0D, 1, 8'h5A);
      rd(4'd2, 8'hCD, "R3 control forced bits");
      // R6 strobe held high: no byte
      wr(4'd2, 8'h0D, 0, 0);
      wr(4'd2, 8'h0C, 0, 0);
      check(irq === 1'b0, "R7 no enable before", irq, 0);
      // R9 polling walk with strobe low
      rd(4'd1, 8'h59, "R9 poll 1");
      rd(4'd1, 8'h19, "R9 poll 2");
      rd(4'd1, 8'hD9, "R9 poll 3");
      rd(4'd1, 8'hD9, "R9 busy freeze");
      // R7 interrupt needs previous enable
      wr(4'd2, 8'h1C, 0, 0);
      check(irq === 1'b0, "R7 enable just set", irq, 0);
      wr(4'd2, 8'h1C, 0, 0);
      check(irq === 1'b1, "R7 irq raised", irq, 1);
      wr(4'd0, 8'h33, 0, 0);
      check(irq === 1'b1, "R7 irq held over data write", irq, 1);
      rd(4'd1, 8'hD9, "R8 status value");
      check(irq === 1'b0, "R8 irq cleared", irq, 0);
      // R4 init low
      wr(4'd2, 8'h08, 0, 0);
      rd(4'd1, 8'hD8, "R4 init status");
      rd(4'd2, 8'hC8, "R3 control init low");
      // R5 second byte, then R6 strobe with select low
      wr(4'd0, 8'hA5, 0, 0);
      wr(4'd2, 8'h0D, 1, 8'hA5);
      wr(4'd2, 8'h04, 0, 0);
      wr(4'd2, 8'h05, 0, 0);
      rd(4'd1, 8'h58, "R9 strobe high freeze 1");
      rd(4'd1, 8'h58, "R9 strobe high freeze 2");
      // R2 aliasing through upper address bit
      rd(4'd10, 8'hC5, "R2 alias control");
      rd(4'd8, 8'hA5, "R2 alias data");
      // R11 unused offsets and status write
      rd(4'd5, 8'hFF, "R11 offset 5");
      rd(4'd7, 8'hFF, "R11 offset 7");
      wr(4'd3, 8'h00, 0, 0);
      wr(4'd1, 8'h00, 0, 0);
      rd(4'd1, 8'h58, "R11 status unchanged");
      rd(4'd2, 8'hC5, "R11 control unchanged");
      rd(4'd0, 8'hA5, "R11 data unchanged");
      // R10 direction in
      @(negedge clk);
      in_data = 8'h77; in_load = 1'b1;
      @(negedge clk);
      in_load = 1'b0;
      wr(4'd2, 8'h2C, 0, 0);
      rd(4'd0, 8'h77, "R10 input latch");
      wr(4'd0, 8'h11, 0, 0);
      rd(4'd0, 8'h77, "R10 input latch kept");
      wr(4'd2, 8'h0C, 0, 0);
      rd(4'd0, 8'h11, "R10 back to written");
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R5 bytes outstanding", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule